// File: doc/BRIEF.md
# Hex Keypad Scanner with Four-Digit Entry

This block drives a 4x4 hexadecimal key matrix and turns each new key press into one hex digit of a short entry register. It pulls one column line low at a time, waits for the lines to settle, and reads the four row lines through a two-flop synchroniser. A key counts as down only after the same column/row code has been seen on several scans of its column in a row. When a key is accepted, the entry register moves its contents one digit to the left and places the new digit in the lowest nibble. A one-cycle strobe marks each accepted key.

Each key yields exactly one digit, however long it is held. The block accepts no further key until the held key's column has read clean for the same number of scans. Readings with two or more rows low in one column are discarded. The column dwell, the settle delay, the number of debounce scans and the register depth are parameters, so a simulation can use short scan periods.

The strobe and the digit register are plain outputs. There is no ready input and no back-pressure: a consumer that needs every digit must capture it on the cycle the strobe is high. The register is also readable at any time as a whole.

Top module: `hexpad_entry`

## Requirements
- R1: Exactly one bit of `col_n` is low at any time. `col_n` = 4'b1110 selects column 1 and `col_n[i]` low selects column i+1. After reset the scan starts at column 1, then moves through columns 2, 3 and 4 before it returns to column 1.
- R2: Each column stays driven for exactly `DWELL` clock cycles before the next column is selected.
- R3: `row_n[i]` low means row i+1 is pulled low. The rows pass through a two-flop synchroniser and are sampled once per column visit, `SETTLE` cycles after that column was selected.
- R4: The key map from column/row to digit is: column 1 gives 1, 4, 7, 0 for rows 1 to 4; column 2 gives 2, 5, 8, F; column 3 gives 3, 6, 9, E; column 4 gives A, B, C, D.
- R5: On each accepted key, `digits` becomes {old `digits`[11:0], new digit} and `key_valid` is high for that one cycle. The update and the strobe appear in the same cycle.
- R6: A key is accepted only after the same single-row code has been read on `DEBOUNCE` consecutive samples of its column. A press that spans fewer samples leaves `digits` unchanged.
- R7: A held key produces exactly one acceptance. No key is accepted again until `DEBOUNCE` consecutive samples of the held key's column show all rows high. A shorter release followed by a new press does not produce a digit.
- R8: A sample with more than one row low is treated as no key and never produces a digit.
- R9: A synchronous active-high `rst` clears `digits` to zero, holds `key_valid` low and restarts the scan at column 1.
- R10: `digits` changes only in a cycle where `key_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_n | input | 4 | Row lines of the key matrix, active low |
| col_n | output | 4 | Column drives, one low at a time |
| digits | output | 4*DIGITS (16) | Entry register; newest digit in bits [3:0] |
| key_valid | output | 1 | One-cycle strobe for each accepted key |

## Verification
A key reaches `digits` at the column sample that completes its debounce count. That sample falls `SETTLE` cycles into the column's slot, and the synchroniser adds two cycles of latency on the input. In the worst case this is about `DEBOUNCE`+1 full scan rounds after the key goes down. Release needs the same amount of time before the next key can be accepted. The bench therefore holds each press for `DEBOUNCE`+2 rounds and each release for the same time, and only then compares `digits` and the strobe count with its model. Tests that must not yield a digit, such as bounce and short release, stay at one round so that their column is sampled at most once. The column checks time each change in negedge-sampled cycles and expect exactly `DWELL` cycles between changes.

// File: rtl/hexpad_pkg.sv
package hexpad_pkg;

  localparam int KP_COLS = 4;
  localparam int KP_ROWS = 4;

  typedef logic [1:0] kidx_t;

  typedef struct packed {
    kidx_t col;
    kidx_t row;
  } keycode_t;

  typedef enum logic {
    KS_IDLE,
    KS_HELD
  } keystate_t;

  // Digit printed on the key at (column, row), both counted from zero
  function automatic logic [3:0] key_digit(input kidx_t col, input kidx_t row);
    logic [3:0] d;
    case ({col, row})
      4'b00_00: d = 4'h1;
      4'b00_01: d = 4'h4;
      4'b00_10: d = 4'h7;
      4'b00_11: d = 4'h0;
      4'b01_00: d = 4'h2;
      4'b01_01: d = 4'h5;
      4'b01_10: d = 4'h8;
      4'b01_11: d = 4'hF;
      4'b10_00: d = 4'h3;
      4'b10_01: d = 4'h6;
      4'b10_10: d = 4'h9;
      4'b10_11: d = 4'hE;
      4'b11_00: d = 4'hA;
      4'b11_01: d = 4'hB;
      4'b11_10: d = 4'hC;
      default:  d = 4'hD;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/hexpad_colscan.sv
module hexpad_colscan
  import hexpad_pkg::*;
#(
  parameter int DWELL  = 100000,
  parameter int SETTLE = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [KP_COLS-1:0]   col_n,
  output kidx_t                col_idx,
  output logic                 sample
);

  localparam int CW = (DWELL > 2) ? $clog2(DWELL) : 1;
  localparam logic [CW-1:0] LAST = CW'(DWELL - 1);
  localparam logic [CW-1:0] SPOT = CW'(SETTLE);

  logic [CW-1:0] dwell_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      dwell_cnt <= '0;
      col_idx   <= '0;
    end else if (dwell_cnt == LAST) begin
      dwell_cnt <= '0;
      col_idx   <= col_idx + kidx_t'(1);
    end else begin
      dwell_cnt <= dwell_cnt + CW'(1);
    end
  end

  for (genvar i = 0; i < KP_COLS; i++) begin : g_col
    assign col_n[i] = (col_idx != kidx_t'(i));
  end

  assign sample = (dwell_cnt == SPOT);

endmodule

// File: rtl/hexpad_rowsync.sv
module hexpad_rowsync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)
        stage_q[s] <= '1;
      else if (s == 0)
        stage_q[s] <= din;
      else
        stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/hexpad_debounce.sv
module hexpad_debounce
  import hexpad_pkg::*;
#(
  parameter int DEBOUNCE = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sample,
  input  kidx_t              col_idx,
  input  logic [KP_ROWS-1:0] row_s,
  output logic               accept,
  output logic [3:0]         acc_digit
);

  localparam int DW = $clog2(DEBOUNCE + 1);
  localparam logic [DW-1:0] DB_N = DW'(DEBOUNCE);

  keystate_t     state_q, state_d;
  keycode_t      cand_q, cand_d;
  logic          cand_vld_q, cand_vld_d;
  logic [DW-1:0] cnt_q, cnt_d;

  logic [KP_ROWS-1:0] row_low;
  logic               one_low;
  logic               any_low;
  kidx_t              row_hit;
  keycode_t           seen;
  logic [DW-1:0]      cnt_inc;

  assign row_low = ~row_s;
  assign one_low = $onehot(row_low);
  assign any_low = |row_low;

  always_comb begin
    row_hit = '0;
    for (int r = 0; r < KP_ROWS; r++) begin
      if (row_low[r]) row_hit = kidx_t'(r);
    end
  end

  assign seen    = '{col: col_idx, row: row_hit};
  assign cnt_inc = cnt_q + DW'(1);

  always_comb begin
    state_d    = state_q;
    cand_d     = cand_q;
    cand_vld_d = cand_vld_q;
    cnt_d      = cnt_q;
    accept     = 1'b0;
    if (sample) begin
      case (state_q)
        KS_IDLE: begin
          if (one_low) begin
            if (cand_vld_q && cand_q == seen) begin
              cnt_d = cnt_inc;
            end else begin
              cand_d     = seen;
              cand_vld_d = 1'b1;
              cnt_d      = DW'(1);
            end
            if (cnt_d == DB_N) begin
              accept     = 1'b1;
              state_d    = KS_HELD;
              cnt_d      = '0;
            end
          end else if (cand_vld_q && cand_q.col == col_idx) begin
            // the candidate's column read no key or several keys
            cand_vld_d = 1'b0;
            cnt_d      = '0;
          end
        end
        default: begin
          if (cand_q.col == col_idx) begin
            if (any_low) begin
              cnt_d = '0;
            end else if (cnt_inc == DB_N) begin
              state_d    = KS_IDLE;
              cand_vld_d = 1'b0;
              cnt_d      = '0;
            end else begin
              cnt_d = cnt_inc;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= KS_IDLE;
      cand_q     <= '0;
      cand_vld_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      state_q    <= state_d;
      cand_q     <= cand_d;
      cand_vld_q <= cand_vld_d;
      cnt_q      <= cnt_d;
    end
  end

  assign acc_digit = key_digit(cand_d.col, cand_d.row);

endmodule

// File: rtl/hexpad_shiftreg.sv
module hexpad_shiftreg #(
  parameter int DIGITS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                accept,
  input  logic [3:0]          new_digit,
  output logic [4*DIGITS-1:0] digits,
  output logic                key_valid
);

  localparam int W = 4 * DIGITS;

  always_ff @(posedge clk) begin
    if (rst) begin
      digits    <= '0;
      key_valid <= 1'b0;
    end else begin
      key_valid <= accept;
      if (accept) digits <= {digits[W-5:0], new_digit};
    end
  end

endmodule

// File: rtl/hexpad_entry.sv
module hexpad_entry
  import hexpad_pkg::*;
#(
  parameter int DWELL    = 100000,
  parameter int SETTLE   = 8,
  parameter int DEBOUNCE = 3,
  parameter int DIGITS   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [3:0]          row_n,
  output logic [3:0]          col_n,
  output logic [4*DIGITS-1:0] digits,
  output logic                key_valid
);

  kidx_t        col_idx;
  logic         sample;
  logic [3:0]   row_s;
  logic         accept;
  logic [3:0]   acc_digit;

  hexpad_colscan #(.DWELL(DWELL), .SETTLE(SETTLE)) u_scan (
    .clk     (clk),
    .rst     (rst),
    .col_n   (col_n),
    .col_idx (col_idx),
    .sample  (sample)
  );

  hexpad_rowsync #(.WIDTH(KP_ROWS), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (row_n),
    .dout (row_s)
  );

  hexpad_debounce #(.DEBOUNCE(DEBOUNCE)) u_deb (
    .clk       (clk),
    .rst       (rst),
    .sample    (sample),
    .col_idx   (col_idx),
    .row_s     (row_s),
    .accept    (accept),
    .acc_digit (acc_digit)
  );

  hexpad_shiftreg #(.DIGITS(DIGITS)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .new_digit (acc_digit),
    .digits    (digits),
    .key_valid (key_valid)
  );

endmodule

// File: rtl/hexpad_entry_chk.sv
module hexpad_entry_chk #(
  parameter int DWELL  = 100000,
  parameter int DIGITS = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [3:0]          col_n,
  input logic [4*DIGITS-1:0] digits,
  input logic                key_valid
);

  localparam int W = 4 * DIGITS;

  logic [3:0] col_prev;
  int         dwell_seen;
  logic       col_chg;

  assign col_chg = (col_n != col_prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      col_prev   <= 4'b1110;
      dwell_seen <= 0;
    end else begin
      col_prev   <= col_n;
      dwell_seen <= col_chg ? 1 : dwell_seen + 1;
    end
  end

  assert_one_col_R1: assert property (@(posedge clk) disable iff (rst)
    $countones(~col_n) == 1);

  assert_col_order_R1: assert property (@(posedge clk) disable iff (rst)
    col_chg |-> col_n == {col_prev[2:0], col_prev[3]});

  assert_dwell_R2: assert property (@(posedge clk) disable iff (rst)
    col_chg |-> dwell_seen == DWELL);

  assert_shift_R5: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> digits[W-1:4] == $past(digits[W-5:0]));

  assert_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> !key_valid);

  assert_reset_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (digits == '0 && !key_valid && col_n == 4'b1110));

  assert_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(digits) |-> key_valid);

endmodule

bind hexpad_entry hexpad_entry_chk #(.DWELL(DWELL), .DIGITS(DIGITS)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .col_n     (col_n),
  .digits    (digits),
  .key_valid (key_valid)
);

// File: tb/hexpad_entry_tb_top.sv
module hexpad_entry_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DWELL      = 40;
  localparam int SETTLE     = 4;
  localparam int DEBOUNCE   = 3;
  localparam int ROUND      = 4 * DWELL;
  localparam int HOLD       = (DEBOUNCE + 2) * ROUND;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  row_n;
  logic [3:0]  col_n;
  logic [15:0] digits;
  logic        key_valid;

  // keypad model: up to two keys down
  logic       ka_dn = 1'b0, kb_dn = 1'b0;
  logic [1:0] ka_c = '0, ka_r = '0, kb_c = '0, kb_r = '0;

  int n_checks = 0;
  int n_fail   = 0;
  int pulses   = 0;
  int wide     = 0;
  logic prev_kv = 1'b0;
  logic [15:0] exp_digits = '0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    row_n = 4'b1111;
    if (ka_dn && !col_n[ka_c]) row_n[ka_r] = 1'b0;
    if (kb_dn && !col_n[kb_c]) row_n[kb_r] = 1'b0;
  end

  hexpad_entry #(.DWELL(DWELL), .SETTLE(SETTLE), .DEBOUNCE(DEBOUNCE), .DIGITS(4)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .row_n     (row_n),
    .col_n     (col_n),
    .digits    (digits),
    .key_valid (key_valid)
  );

  always @(negedge clk) begin
    if (rst) begin
      prev_kv = 1'b0;
    end else begin
      if (key_valid) pulses++;
      if (key_valid && prev_kv) wide++;
      prev_kv = key_valid;
    end
  end

  function automatic logic [3:0] face(input int c, input int r);
    logic [3:0] col1 [4] = '{4'h1, 4'h4, 4'h7, 4'h0};
    logic [3:0] col2 [4] = '{4'h2, 4'h5, 4'h8, 4'hF};
    logic [3:0] col3 [4] = '{4'h3, 4'h6, 4'h9, 4'hE};
    logic [3:0] col4 [4] = '{4'hA, 4'hB, 4'hC, 4'hD};
    case (c)
      0: return col1[r];
      1: return col2[r];
      2: return col3[r];
      default: return col4[r];
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // full press and release of one key, then compare against the model
  task automatic tap(input int c, input int r, input string tag);
    int p0;
    p0 = pulses;
    ka_c = 2'(c); ka_r = 2'(r); ka_dn = 1'b1;
    cycles(HOLD);
    ka_dn = 1'b0;
    cycles(HOLD);
    exp_digits = {exp_digits[11:0], face(c, r)};
    check(digits == exp_digits, tag, 32'(digits), 32'(exp_digits));
    check(pulses - p0 == 1, {tag, " strobe count"}, 32'(pulses - p0), 32'd1);
  endtask

  initial begin
    logic [3:0] last_col;
    int gap;
    int p0;
    void'($urandom(32'd1234));
    cycles(5);
    rst = 1'b0;
    cycles(1);
    // R9: reset state
    check(digits == 16'h0, "R9 digits after reset", 32'(digits), 32'h0);
    check(key_valid == 1'b0, "R9 strobe after reset", 32'(key_valid), 32'h0);
    check(col_n == 4'b1110, "R1 first column", 32'(col_n), 32'he);

    // R1/R2: column order and dwell
    last_col = col_n;
    while (col_n == last_col) cycles(1);
    for (int k = 0; k < 4; k++) begin
      last_col = col_n;
      gap = 0;
      while (col_n == last_col) begin
        cycles(1);
        gap++;
      end
      check(col_n == {last_col[2:0], last_col[3]}, "R1 column order", 32'(col_n),
            32'({last_col[2:0], last_col[3]}));
      check(gap == DWELL, "R2 dwell length", 32'(gap), 32'(DWELL));
    end

    // R3/R4/R5: every key once, in map order
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        tap(c, r, $sformatf("R4 key c%0d r%0d (R3 R5)", c, r));
    check(wide == 0, "R5 strobe width", 32'(wide), 32'd0);

    // R6: bounce shorter than the debounce count
    p0 = pulses;
    ka_c = 2'd1; ka_r = 2'd2; ka_dn = 1'b1;
    cycles(ROUND);
    ka_dn = 1'b0;
    cycles(HOLD);
    check(digits == exp_digits, "R6 bounce ignored", 32'(digits), 32'(exp_digits));
    check(pulses == p0, "R6 bounce no strobe (R10)", 32'(pulses - p0), 32'd0);

    // R8: two rows low in one column
    p0 = pulses;
    ka_c = 2'd2; ka_r = 2'd0; kb_c = 2'd2; kb_r = 2'd3;
    ka_dn = 1'b1; kb_dn = 1'b1;
    cycles(2 * HOLD);
    ka_dn = 1'b0; kb_dn = 1'b0;
    cycles(HOLD);
    check(digits == exp_digits, "R8 multi-row ignored", 32'(digits), 32'(exp_digits));
    check(pulses == p0, "R8 no strobe", 32'(pulses - p0), 32'd0);

    // R7: long hold, short release, press again
    p0 = pulses;
    ka_c = 2'd3; ka_r = 2'd1; ka_dn = 1'b1;
    cycles(3 * HOLD);
    ka_dn = 1'b0;
    cycles(ROUND);
    ka_dn = 1'b1;
    cycles(2 * HOLD);
    ka_dn = 1'b0;
    cycles(HOLD);
    exp_digits = {exp_digits[11:0], face(3, 1)};
    check(digits == exp_digits, "R7 one digit per hold", 32'(digits), 32'(exp_digits));
    check(pulses - p0 == 1, "R7 single strobe", 32'(pulses - p0), 32'd1);
    tap(0, 3, "R7 accepted after full release");

    // random sequence
    for (int i = 0; i < 12; i++) begin
      int c, r;
      c = int'($urandom_range(3, 0));
      r = int'($urandom_range(3, 0));
      tap(c, r, $sformatf("R5 random entry %0d (R4)", i));
    end

    // R9: reset in the middle of use
    rst = 1'b1;
    cycles(2);
    rst = 1'b0;
    exp_digits = '0;
    cycles(1);
    check(digits == 16'h0, "R9 mid-run reset", 32'(digits), 32'h0);
    check(col_n == 4'b1110, "R9 scan restart", 32'(col_n), 32'he);
    tap(1, 1, "R9 entry after reset");
    check(wide == 0, "R5 strobe width final", 32'(wide), 32'd0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule